// File: doc/BRIEF.md
# Common Interrupt Router

This block takes a set of shared level-sensitive interrupt inputs and delivers each one to one core out of a small group. A command port sets up every shared interrupt. Each interrupt has a destination core mask, a mode word and a mask bit. A global enable command switches delivery on for the whole block.

An interrupt can run in one of two distribution schemes. In round-robin, successive deliveries rotate through the cores whose bits are set in its destination mask. In fixed mode, every delivery goes to one core. For each core the block drives a vector of core-side interrupt lines. Shared interrupt n lands on line LINE_BASE+n of that vector, and the lower lines are kept free for sources that belong to a single core.

Top module: `common_irq_router`

## Requirements
- R1: After reset, every output line is low. Every interrupt starts masked, with an all-zero destination mask and mode "level, round-robin". The global enable starts off.
- R2: A command is taken on a clock edge where cmd_valid_i is high. cmd_op_i selects the command: 0 writes the destination mask from cmd_data_i[NUM_CORES-1:0], 1 writes the mode word, 2 writes the mask bit from cmd_data_i[0], and 3 sets the global enable. The new setting acts on the lines from the following clock edge.
- R3: No line is asserted while the global enable is off, whatever the inputs and the per-interrupt setup.
- R4: Interrupt n on core c drives bit c*(LINE_BASE+NUM_IRQ)+LINE_BASE+n of irq_lines_o. Bits below LINE_BASE in every core's slice are always low. At most one core carries a given interrupt at any time.
- R5: In level mode (mode bit 4 = 1), the chosen line rises one cycle after the input is sampled high. It stays high while the input stays high and delivery is allowed, and it falls one cycle after the input is sampled low.
- R6: In round-robin mode (mode bits [1:0] = 00), each new delivery goes to the first core in the destination mask at or after the pointer, searching upward and wrapping from the last core to core 0. The pointer starts at core 0 and moves to the core after the one just chosen. Cores whose mask bit is clear are skipped.
- R7: When mode bits [1:0] are not 00, every delivery goes to the lowest-numbered core in the destination mask. Mode bits other than [1:0] and 4 have no effect.
- R8: While an interrupt's mask bit is 1, it is not delivered. Masking an interrupt that is already on a line drops that line one cycle after the mask takes effect. Clearing the mask bit while the input is still high starts a fresh delivery.
- R9: An interrupt whose destination mask is all zero is never delivered.
- R10: In edge mode (mode bit 4 = 0), each rising edge of the input gives a one-cycle pulse on the chosen line, even if the input stays high.
- R11: A line only ever rises on a core whose bit was set in that interrupt's destination mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (0 destination, 1 mode, 2 mask, 3 enable) |
| cmd_sel_i | input | SEL_W | Index of the shared interrupt the command targets |
| cmd_data_i | input | DATA_W | Command data |
| irq_i | input | NUM_IRQ | Shared interrupt inputs, level sensitive |
| irq_lines_o | output | NUM_CORES*(LINE_BASE+NUM_IRQ) | Core-side interrupt lines, one slice per core |

## Verification
The assertions assume three things about the inputs. The interrupt inputs change in step with the clock and already pass through a synchronizer. cmd_sel_i names an interrupt that exists. At most one command arrives per cycle. The bench meets these by driving every input, commands included, half a clock period away from the sampling edge, and by keeping every index below NUM_IRQ. With those assumptions, the properties check four things: no line is raised for a disabled or masked interrupt, no interrupt appears on two cores at once, a level delivery is never dropped while its input holds, and a line only rises on a core that belonged to the destination mask.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
   typedef enum logic [1:0] {
      OP_DEST   = 2'd0,
      OP_MODE   = 2'd1,
      OP_MASK   = 2'd2,
      OP_ENABLE = 2'd3
   } cirq_op_e;

   localparam int          MODE_LVL_BIT = 4;
   localparam logic [1:0]  DISTR_RR     = 2'b00;
endpackage

// File: rtl/cirq_cfg.sv
module cirq_cfg #(
   parameter int NUM_IRQ   = 8,
   parameter int NUM_CORES = 4,
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 3
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           cmd_valid_i,
   input  logic [1:0]                     cmd_op_i,
   input  logic [SEL_W-1:0]               cmd_sel_i,
   input  logic [DATA_W-1:0]              cmd_data_i,
   output logic [NUM_IRQ*NUM_CORES-1:0]   dest_o,
   output logic [2*NUM_IRQ-1:0]           distr_o,
   output logic [NUM_IRQ-1:0]             lvl_o,
   output logic [NUM_IRQ-1:0]             mask_o,
   output logic                           en_o
);
   import cirq_pkg::*;

   logic unused_data;
   assign unused_data = ^cmd_data_i;

   cirq_op_e op;
   assign op = cirq_op_e'(cmd_op_i);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
      logic hit;
      assign hit = cmd_valid_i && (cmd_sel_i == SEL_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            dest_o[i*NUM_CORES +: NUM_CORES] <= '0;
            distr_o[2*i +: 2]                <= DISTR_RR;
            lvl_o[i]                         <= 1'b1;
            mask_o[i]                        <= 1'b1;
         end else if (hit) begin
            case (op)
               OP_DEST: dest_o[i*NUM_CORES +: NUM_CORES] <= cmd_data_i[NUM_CORES-1:0];
               OP_MODE: begin
                  distr_o[2*i +: 2] <= cmd_data_i[1:0];
                  lvl_o[i]          <= cmd_data_i[MODE_LVL_BIT];
               end
               OP_MASK: mask_o[i] <= cmd_data_i[0];
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                en_o <= 1'b0;
      else if (cmd_valid_i && op == OP_ENABLE)    en_o <= 1'b1;
   end
endmodule

// File: rtl/cirq_pick.sv
module cirq_pick #(
   parameter int NUM_CORES = 4,
   parameter int CW        = 2
) (
   input  logic [NUM_CORES-1:0] dest_i,
   input  logic [CW-1:0]        ptr_i,
   input  logic                 rr_i,
   output logic [CW-1:0]        core_o,
   output logic [CW-1:0]        next_o
);
   if (NUM_CORES == 1) begin : g_single
      logic unused_in;
      assign unused_in = ^{dest_i, ptr_i, rr_i};
      assign core_o    = '0;
      assign next_o    = '0;
   end else begin : g_multi
      always_comb begin
         core_o = '0;
         for (int off = NUM_CORES - 1; off >= 0; off--) begin
            int idx;
            idx = rr_i ? ((int'(ptr_i) + off) % NUM_CORES) : off;
            if (dest_i[idx]) core_o = CW'(idx);
         end
         next_o = (core_o == CW'(NUM_CORES - 1)) ? '0 : core_o + 1'b1;
      end
   end
endmodule

// File: rtl/cirq_lane.sv
module cirq_lane #(
   parameter int NUM_CORES = 4,
   parameter int CW        = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 irq_i,
   input  logic                 ok_i,
   input  logic                 lvl_i,
   input  logic                 rr_i,
   input  logic [NUM_CORES-1:0] dest_i,
   output logic                 active_o,
   output logic [CW-1:0]        core_o
);
   logic          prev_q;
   logic [CW-1:0] ptr_q;
   logic [CW-1:0] pick_core, pick_next;
   logic          start;

   cirq_pick #(.NUM_CORES(NUM_CORES), .CW(CW)) u_pick (
      .dest_i (dest_i),
      .ptr_i  (ptr_q),
      .rr_i   (rr_i),
      .core_o (pick_core),
      .next_o (pick_next)
   );

   assign start = ok_i && (lvl_i ? (irq_i && !active_o) : (irq_i && !prev_q));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= 1'b0;
         active_o <= 1'b0;
         core_o   <= '0;
         ptr_q    <= '0;
      end else begin
         prev_q <= irq_i;
         if (start) begin
            active_o <= 1'b1;
            core_o   <= pick_core;
            ptr_q    <= pick_next;
         end else begin
            active_o <= lvl_i && active_o && irq_i && ok_i;
         end
      end
   end
endmodule

// File: rtl/common_irq_router.sv
module common_irq_router #(
   parameter int  NUM_IRQ   = 8,
   parameter int  NUM_CORES = 4,
   parameter int  LINE_BASE = 24,
   parameter int  DATA_W    = 32,
   localparam int SEL_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
   localparam int LINE_W    = LINE_BASE + NUM_IRQ
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        cmd_valid_i,
   input  logic [1:0]                  cmd_op_i,
   input  logic [SEL_W-1:0]            cmd_sel_i,
   input  logic [DATA_W-1:0]           cmd_data_i,
   input  logic [NUM_IRQ-1:0]          irq_i,
   output logic [NUM_CORES*LINE_W-1:0] irq_lines_o
);
   import cirq_pkg::*;

   localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

   if (NUM_CORES < 1 || NUM_CORES > 16) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..16");
   end
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end
   if (DATA_W <= MODE_LVL_BIT || DATA_W < NUM_CORES) begin : g_bad_data
      $error("DATA_W too narrow for mode word or core mask");
   end
   if (LINE_BASE < 0) begin : g_bad_base
      $error("LINE_BASE must not be negative");
   end

   logic [NUM_IRQ*NUM_CORES-1:0] cfg_dest;
   logic [2*NUM_IRQ-1:0]         cfg_distr;
   logic [NUM_IRQ-1:0]           cfg_lvl;
   logic [NUM_IRQ-1:0]           cfg_mask;
   logic                         cfg_en;
   logic [NUM_IRQ-1:0]           fwd_ok;
   logic [NUM_IRQ-1:0]           lane_act;
   logic [CW-1:0]                lane_core [NUM_IRQ];

   cirq_cfg #(
      .NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .SEL_W(SEL_W)
   ) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .cmd_sel_i   (cmd_sel_i),
      .cmd_data_i  (cmd_data_i),
      .dest_o      (cfg_dest),
      .distr_o     (cfg_distr),
      .lvl_o       (cfg_lvl),
      .mask_o      (cfg_mask),
      .en_o        (cfg_en)
   );

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_lane
      assign fwd_ok[n] = cfg_en && !cfg_mask[n] && (|cfg_dest[n*NUM_CORES +: NUM_CORES]);

      cirq_lane #(.NUM_CORES(NUM_CORES), .CW(CW)) u_lane (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .irq_i    (irq_i[n]),
         .ok_i     (fwd_ok[n]),
         .lvl_i    (cfg_lvl[n]),
         .rr_i     (cfg_distr[2*n +: 2] == DISTR_RR),
         .dest_i   (cfg_dest[n*NUM_CORES +: NUM_CORES]),
         .active_o (lane_act[n]),
         .core_o   (lane_core[n])
      );
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      if (LINE_BASE > 0) begin : g_rsvd
         assign irq_lines_o[c*LINE_W +: LINE_BASE] = '0;
      end
      for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
         assign irq_lines_o[c*LINE_W + LINE_BASE + n] =
            lane_act[n] && (lane_core[n] == CW'(c));
      end
   end
endmodule

// File: rtl/cirq_router_chk.sv
module cirq_router_chk #(
   parameter int NUM_IRQ   = 8,
   parameter int NUM_CORES = 4,
   parameter int LINE_BASE = 24,
   parameter int LINE_W    = 32
) (
   input logic                          clk_i,
   input logic                          rst_ni,
   input logic [NUM_IRQ-1:0]            irq_i,
   input logic [NUM_CORES*LINE_W-1:0]   irq_lines_o,
   input logic [NUM_IRQ*NUM_CORES-1:0]  dest_i,
   input logic [NUM_IRQ-1:0]            lvl_i,
   input logic [NUM_IRQ-1:0]            mask_i,
   input logic [NUM_IRQ-1:0]            ok_i,
   input logic                          en_i
);
   // R3
   no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> (irq_lines_o == '0));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      if (LINE_BASE > 0) begin : g_r
         // R4
         reserved_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_lines_o[c*LINE_W +: LINE_BASE] == '0);
      end
   end

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_n
      logic [NUM_CORES-1:0] col;
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
         assign col[c] = irq_lines_o[c*LINE_W + LINE_BASE + n];

         // R5
         level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (col[c] && irq_i[n] && ok_i[n] && lvl_i[n]) |=> col[c]);

         // R11
         dest_member_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(col[c]) |-> $past(dest_i[n*NUM_CORES + c]));
      end

      // R4
      one_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $onehot0(col));

      // R8
      mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         mask_i[n] |=> (col == '0));
   end
endmodule

bind common_irq_router cirq_router_chk #(
   .NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .LINE_BASE(LINE_BASE), .LINE_W(LINE_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_i       (irq_i),
   .irq_lines_o (irq_lines_o),
   .dest_i      (cfg_dest),
   .lvl_i       (cfg_lvl),
   .mask_i      (cfg_mask),
   .ok_i        (fwd_ok),
   .en_i        (cfg_en)
);

// File: tb/test_common_irq_router.sv
`timescale 1ns/1ps
module test_common_irq_router;
   localparam int NI = 8;
   localparam int NC = 4;
   localparam int LB = 24;
   localparam int LW = LB + NI;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = '0;
   logic [2:0]        cmd_sel = '0;
   logic [31:0]       cmd_data = '0;
   logic [NI-1:0]     irq = '0;
   logic [NC*LW-1:0]  lines;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   common_irq_router #(.NUM_IRQ(NI), .NUM_CORES(NC), .LINE_BASE(LB), .DATA_W(32))
   i_common_irq_router (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
      .cmd_sel_i(cmd_sel), .cmd_data_i(cmd_data), .irq_i(irq), .irq_lines_o(lines)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic send(input logic [1:0] op, input int sel, input logic [31:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_sel = 3'(sel); cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   function automatic int which_core(input int n);
      int hits = 0;
      int found = -1;
      for (int c = 0; c < NC; c++) begin
         if (lines[c*LW + LB + n]) begin hits++; found = c; end
      end
      return (hits > 1) ? -2 : found;
   endfunction

   task automatic t_reset();
      check(lines == '0, "R1 reset lines", int'(|lines), 0);
   endtask

   task automatic t_enable_gate();
      send(2'd0, 0, 32'h1);
      send(2'd2, 0, 32'h0);
      irq[0] = 1'b1;
      cyc(3);
      check(lines == '0, "R3 no delivery before enable", int'(|lines), 0);
      send(2'd3, 0, 32'h0);
      cyc(1);
      check(which_core(0) == 0, "R3 delivery after enable", which_core(0), 0);
      check(lines[LB] == 1'b1, "R4 core0 line LINE_BASE+0", int'(lines[LB]), 1);
      irq[0] = 1'b0;
      cyc(1);
      check(which_core(0) == -1, "R5 line falls", which_core(0), -1);
   endtask

   task automatic t_default_mask();
      send(2'd0, 6, 32'h1);
      irq[6] = 1'b1;
      cyc(3);
      check(which_core(6) == -1, "R1 default masked", which_core(6), -1);
      irq[6] = 1'b0;
      cyc(1);
   endtask

   task automatic t_round_robin();
      int exp [5] = '{0, 1, 3, 0, 1};
      send(2'd0, 1, 32'hB);
      send(2'd1, 1, 32'h10);
      send(2'd2, 1, 32'h0);
      foreach (exp[i]) begin
         irq[1] = 1'b1;
         cyc(1);
         check(which_core(1) == exp[i], "R6 round-robin order", which_core(1), exp[i]);
         cyc(2);
         check(which_core(1) == exp[i], "R5 level hold", which_core(1), exp[i]);
         irq[1] = 1'b0;
         cyc(1);
         check(which_core(1) == -1, "R5 release", which_core(1), -1);
      end
   endtask

   task automatic t_fixed();
      send(2'd0, 2, 32'h6);
      send(2'd1, 2, 32'hFFFF_FF11);
      send(2'd2, 2, 32'h0);
      for (int i = 0; i < 3; i++) begin
         irq[2] = 1'b1;
         cyc(2);
         check(which_core(2) == 1, "R7 fixed lowest core", which_core(2), 1);
         irq[2] = 1'b0;
         cyc(1);
      end
   endtask

   task automatic t_mask();
      send(2'd0, 3, 32'h4);
      send(2'd1, 3, 32'h10);
      send(2'd2, 3, 32'h0);
      irq[3] = 1'b1;
      cyc(1);
      check(which_core(3) == 2, "R8 unmasked delivery", which_core(3), 2);
      send(2'd2, 3, 32'h1);
      cyc(1);
      check(which_core(3) == -1, "R8 masked drops line", which_core(3), -1);
      send(2'd2, 3, 32'h0);
      cyc(1);
      check(which_core(3) == 2, "R8 unmask restarts", which_core(3), 2);
      irq[3] = 1'b0;
      cyc(1);
   endtask

   task automatic t_zero_dest();
      send(2'd1, 4, 32'h10);
      send(2'd2, 4, 32'h0);
      irq[4] = 1'b1;
      cyc(3);
      check(lines == '0, "R9 zero mask never delivered", int'(|lines), 0);
      irq[4] = 1'b0;
      cyc(1);
   endtask

   task automatic t_edge();
      send(2'd0, 5, 32'h1);
      send(2'd1, 5, 32'h0);
      send(2'd2, 5, 32'h0);
      irq[5] = 1'b1;
      cyc(1);
      check(which_core(5) == 0, "R10 edge pulse high", which_core(5), 0);
      cyc(1);
      check(which_core(5) == -1, "R10 pulse one cycle", which_core(5), -1);
      cyc(2);
      check(which_core(5) == -1, "R10 no repeat while high", which_core(5), -1);
      irq[5] = 1'b0;
      cyc(1);
      irq[5] = 1'b1;
      cyc(1);
      check(which_core(5) == 0, "R10 second edge", which_core(5), 0);
      irq[5] = 1'b0;
      cyc(1);
   endtask

   task automatic t_line_map();
      logic [NC*LW-1:0] exp_v;
      exp_v = '0;
      exp_v[3*LW + LB + 7] = 1'b1;
      send(2'd0, 7, 32'h8);
      send(2'd1, 7, 32'h10);
      send(2'd2, 7, 32'h0);
      irq[7] = 1'b1;
      cyc(1);
      check(lines == exp_v, "R4 line position core3 irq7", int'(|(lines ^ exp_v)), 0);
      check(which_core(7) == 3, "R2 settings applied", which_core(7), 3);
      irq[7] = 1'b0;
      cyc(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_enable_gate();
      t_default_mask();
      t_round_robin();
      t_fixed();
      t_mask();
      t_zero_dest();
      t_edge();
      t_line_map();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule